// File: doc/BRIEF.md
# Low-Battery Wakeup Charge Controller

This block revives a deeply discharged battery by injecting a small, fixed charge current for a bounded time. The host arms it by writing an enable bit. While that bit is set and a comparator reports that the battery sits below the minimum system voltage, the block presents a charge-current override with a valid flag. The charger's current loop uses this override in place of the programmed charge current.

The wakeup charge ends in one of four ways:
- the battery recovers above the minimum;
- the host writes a new charge-current value;
- a timeout measured in 1 s ticks expires;
- the host clears the enable bit.

In the first three cases the block clears its own enable bit, so the host reads back that the wakeup has finished.

The controller has two states. REST means no override is driven. WAKE means the override is driven. Transitions:
- T_START goes from REST to WAKE when the enable bit is high, the battery is low and there is no host current write in that cycle.
- T_RECOVER goes from WAKE to REST when the battery is no longer low.
- T_HOSTSET goes from WAKE to REST on a host current write.
- T_EXPIRE goes from WAKE to REST when the timeout expires.
- T_ABORT goes from WAKE to REST when the enable bit reads low.

Top module: `lwc_wake_ctrl`

## Requirements
- R1: After reset the override valid flag is 0, the override code is 0, the enable readback is 0 and the controller is in REST.
- R2: A host enable write (`en_wr`) loads `en_wdata` into the enable bit. The bit is visible on `en_rdbk` from the next cycle, unless R9 applies.
- R3: In REST with the enable bit high, `batt_low` high and no `ichg_wr`, the override becomes valid on the next cycle. While valid, the code equals 128 mA in 64 mA steps, which is 2. While not valid, the code is 0.
- R4: With the enable bit high and `batt_low` low, no override is started and the enable bit remains set.
- R5: When `batt_low` is low during the wakeup charge, the override is removed and the enable bit is cleared on the next cycle.
- R6: A host charge-current write (`ichg_wr`) in any state clears the enable bit on the next cycle. It also removes any override on the next cycle and prevents a start in that cycle.
- R7: The timeout counts `tick_1s` pulses seen in cycles where the override is valid. The `TIMEOUT_SEC`-th such pulse removes the override and clears the enable bit on the next cycle.
- R8: A host write of 0 to the enable bit during the wakeup charge removes the override one cycle after the readback shows 0.
- R9: A clearing event (R5, R6, R7) takes priority over a host enable write in the same cycle.
- R10: The override never stays valid across more than `TIMEOUT_SEC` tick pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Host write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| batt_low | input | 1 | Comparator flag: battery below minimum system voltage |
| ichg_wr | input | 1 | Host write of a new charge-current value |
| tick_1s | input | 1 | One-cycle pulse every second |
| ovr_code | output | CODE_W | Override charge-current code (64 mA per step) |
| ovr_valid | output | 1 | Override is in force |
| en_rdbk | output | 1 | Enable bit readback |

## Verification
The bench builds the block with `TIMEOUT_SEC` set to 4, so a few ticks reach the expiry transition T_EXPIRE and the bound of R10. It keeps the default 128 mA and 64 mA step values, which puts the override code at 2. With this short window, random tick densities hit the case where expiry coincides with battery recovery or a host write. They also hit the case where a start coincides with a tick that must not be counted.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
    typedef enum logic [0:0] {
        ST_REST = 1'b0,
        ST_WAKE = 1'b1
    } lwc_state_e;
endpackage

// File: rtl/lwc_enable_bit.sv
module lwc_enable_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wdata,
    input  logic clr,
    output logic q
);
    // A clear from the controller wins over a host write in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= 1'b0;
        else if (clr)
            q <= 1'b0;
        else if (wr)
            q <= wdata;
    end
endmodule

// File: rtl/lwc_sec_timer.sv
module lwc_sec_timer #(
    parameter int unsigned LIMIT = 1800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (tick && cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && tick && (cnt_q == LAST);
endmodule

// File: rtl/lwc_wake_ctrl.sv
module lwc_wake_ctrl #(
    parameter int unsigned TIMEOUT_SEC = 1800,
    parameter int unsigned WAKE_MA     = 128,
    parameter int unsigned STEP_MA     = 64,
    parameter int unsigned CODE_W      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              batt_low,
    input  logic              ichg_wr,
    input  logic              tick_1s,
    output logic [CODE_W-1:0] ovr_code,
    output logic              ovr_valid,
    output logic              en_rdbk
);
    import lwc_pkg::*;

    localparam logic [CODE_W-1:0] WAKE_CODE = CODE_W'(WAKE_MA / STEP_MA);

    lwc_state_e state_q, state_d;
    logic       en_q;
    logic       charging;
    logic       expire;
    logic       clr_en;

    assign charging = (state_q == ST_WAKE);

    // Every ending cause except an abort clears the enable bit.
    assign clr_en = ichg_wr || (charging && (!batt_low || expire));

    lwc_enable_bit u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (en_wr),
        .wdata (en_wdata),
        .clr   (clr_en),
        .q     (en_q)
    );

    lwc_sec_timer #(.LIMIT(TIMEOUT_SEC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (charging),
        .tick   (tick_1s),
        .expire (expire)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_REST;
        else
            state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_REST: begin
                if (en_q && batt_low && !ichg_wr)
                    state_d = ST_WAKE;            // T_START
            end
            ST_WAKE: begin
                if (ichg_wr)
                    state_d = ST_REST;            // T_HOSTSET
                else if (!batt_low)
                    state_d = ST_REST;            // T_RECOVER
                else if (expire)
                    state_d = ST_REST;            // T_EXPIRE
                else if (!en_q)
                    state_d = ST_REST;            // T_ABORT
            end
            default: state_d = ST_REST;
        endcase
    end

    // Outputs
    always_comb begin
        ovr_valid = 1'b0;
        ovr_code  = '0;
        unique case (state_q)
            ST_REST: ;
            ST_WAKE: begin
                ovr_valid = 1'b1;
                ovr_code  = WAKE_CODE;
            end
            default: ;
        endcase
    end

    assign en_rdbk = en_q;
endmodule

// File: rtl/lwc_wake_ctrl_chk.sv
module lwc_wake_ctrl_chk #(
    parameter int unsigned TIMEOUT_SEC = 1800,
    parameter int unsigned WAKE_MA     = 128,
    parameter int unsigned STEP_MA     = 64,
    parameter int unsigned CODE_W      = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_wr,
    input logic              en_wdata,
    input logic              batt_low,
    input logic              ichg_wr,
    input logic              tick_1s,
    input logic [CODE_W-1:0] ovr_code,
    input logic              ovr_valid,
    input logic              en_rdbk
);
    localparam int unsigned TW = $clog2(TIMEOUT_SEC + 2);

    logic [TW-1:0] ticks_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ticks_q <= '0;
        else if (!ovr_valid)
            ticks_q <= '0;
        else if (tick_1s && ticks_q != {TW{1'b1}})
            ticks_q <= ticks_q + 1'b1;
    end

    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_valid && en_rdbk && batt_low && !ichg_wr) |=> ovr_valid);

    a_r3_code: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_valid |-> (ovr_code == CODE_W'(WAKE_MA / STEP_MA)));

    a_r4_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_valid && !batt_low) |=> !ovr_valid);

    a_r4_keep_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rdbk && !batt_low && !ichg_wr && !en_wr && !ovr_valid) |=> en_rdbk);

    a_r5_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_valid && !batt_low) |=> (!ovr_valid && !en_rdbk));

    a_r6_host_write: assert property (@(posedge clk) disable iff (!rst_n)
        ichg_wr |=> (!ovr_valid && !en_rdbk));

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ichg_wr && en_wr && en_wdata) |=> !en_rdbk);

    a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ticks_q <= TW'(TIMEOUT_SEC));
endmodule

bind lwc_wake_ctrl lwc_wake_ctrl_chk #(
    .TIMEOUT_SEC (TIMEOUT_SEC),
    .WAKE_MA     (WAKE_MA),
    .STEP_MA     (STEP_MA),
    .CODE_W      (CODE_W)
) u_chk (.*);

// File: tb/lwc_wake_ctrl_tb_top.sv
module lwc_wake_ctrl_tb_top;
    localparam int unsigned T_SEC  = 4;
    localparam int unsigned CODE_W = 7;
    localparam logic [CODE_W-1:0] EXP_CODE = 7'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_wr = 1'b0, en_wdata = 1'b0, batt_low = 1'b0, ichg_wr = 1'b0, tick_1s = 1'b0;
    logic [CODE_W-1:0] ovr_code;
    logic ovr_valid, en_rdbk;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // reference model state
    bit m_en = 0, m_chg = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    lwc_wake_ctrl #(.TIMEOUT_SEC(T_SEC), .CODE_W(CODE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .batt_low(batt_low), .ichg_wr(ichg_wr), .tick_1s(tick_1s),
        .ovr_code(ovr_code), .ovr_valid(ovr_valid), .en_rdbk(en_rdbk)
    );

    function automatic logic [CODE_W-1:0] exp_code(bit chg);
        return chg ? EXP_CODE : '0;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_en = 0; m_chg = 0; m_cnt = 0;
        end else begin
            bit tmo, clr, nchg;
            tmo  = m_chg && tick_1s && (m_cnt == T_SEC - 1);
            clr  = ichg_wr || (m_chg && (!batt_low || tmo));
            nchg = m_chg ? !(!m_en || ichg_wr || !batt_low || tmo)
                         : (m_en && batt_low && !ichg_wr);
            if (!m_chg) m_cnt = 0;
            else if (tick_1s) m_cnt = m_cnt + 1;
            m_en  = clr ? 1'b0 : (en_wr ? en_wdata : m_en);
            m_chg = nchg;
        end
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic check(string req);
        vectors++;
        if (ovr_valid !== m_chg || ovr_code !== exp_code(m_chg) || en_rdbk !== m_en) begin
            errors++;
            $display("FAIL %s: actual valid=%0b code=%0d en=%0b expected valid=%0b code=%0d en=%0b",
                     req, ovr_valid, ovr_code, en_rdbk, m_chg, exp_code(m_chg), m_en);
        end
    endtask

    task automatic step(bit ew, bit ed, bit low, bit iw, bit tk, string req);
        @(negedge clk);
        check(req);
        en_wr = ew; en_wdata = ed; batt_low = low; ichg_wr = iw; tick_1s = tk;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1");
        // R2: write enable, battery high
        step(1, 1, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 1, "R2");
        // R4: armed but battery high, ticks present
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, i[0], "R4");
        // R3: battery drops, start with a tick on the start cycle
        step(0, 0, 1, 0, 1, "R4");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, "R3");
        // R5: recovery
        step(0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, "R5");
        // R6: host current write during charge
        step(1, 1, 1, 0, 0, "R6");
        step(0, 0, 1, 0, 0, "R6");
        step(0, 0, 1, 1, 0, "R6");
        step(0, 0, 1, 0, 0, "R6");
        step(0, 0, 1, 0, 0, "R6");
        // R6: host current write while armed in rest blocks start
        step(1, 1, 0, 0, 0, "R6");
        step(0, 0, 1, 1, 0, "R6");
        step(0, 0, 1, 0, 0, "R6");
        // R7: timeout
        step(1, 1, 1, 0, 0, "R7");
        for (int i = 0; i < 12; i++) step(0, 0, 1, 0, 1, "R7");
        step(0, 0, 1, 0, 0, "R7");
        // R8: host clears enable during charge
        step(1, 1, 1, 0, 0, "R8");
        step(0, 0, 1, 0, 0, "R8");
        step(1, 0, 1, 0, 0, "R8");
        step(0, 0, 1, 0, 0, "R8");
        step(0, 0, 1, 0, 0, "R8");
        // R9: host write of 1 together with current write
        step(1, 1, 1, 1, 0, "R9");
        step(0, 0, 1, 0, 0, "R9");
        step(0, 0, 1, 0, 0, "R9");
        // R10: random mix
        begin
            bit low = 1;
            for (int i = 0; i < 4000; i++) begin
                bit ew, ed, iw, tk;
                if ($urandom_range(31) == 0) low = !low;
                ew = ($urandom_range(11) == 0);
                ed = ($urandom_range(3) != 0);
                iw = ($urandom_range(63) == 0);
                tk = ($urandom_range(3) == 0);
                step(ew, ed, low, iw, tk, "R10");
            end
        end
        step(0, 0, 0, 0, 0, "R10");
        @(negedge clk);
        check("R10");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule